// File: doc/BRIEF.md
# LIN Slave Node Mode Controller

This block is the digital control core of a LIN slave node that has its own on-chip voltage regulator. It decides which of five operating modes the node is in: Unpowered, Pre-normal, Normal, Silent or Sleep. The inputs are a supply-good flag, a regulator undervoltage flag, the enable and transmit-data pins from the host microcontroller, and a pulse that reports a validated bus wake-up. From the current mode it drives the regulator on/off and tolerance controls, the transmit-path and slave-termination enables, the active-low host reset, and a request that pulls the transmit-data pin low.

Every timed interval counts a clock-enable `tick` and not raw clocks. Analog thresholds, bus filtering, slope shaping and protection circuits are outside this block and reach it only as digital flags. The host asks for low-power modes with a falling edge on the enable pin. The transmit-data level seen at that edge decides between Silent and Sleep. Every path back from undervoltage or a wake-up passes through Pre-normal.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While `supply_ok` is low the mode is Unpowered (`mode_code` = 5'b00001), with `reg_en` = 0 and `nres` = 0. The first clock edge with `supply_ok` high enters Pre-normal (`mode_code` = 5'b00010), whatever the level of `en_pin`.
- R2: In Pre-normal `reg_en` = 1, `reg_tight` = 1, `tx_en` = 0 and `term_en` = 1. After entry from Unpowered, from Sleep or through undervoltage, `nres` stays 0 and every mode change other than loss of supply is refused until RESET_TICKS ticks have elapsed.
- R3: The reset-hold count advances only on cycles with `tick` high. It restarts from zero on every cycle that `vcc_uv` is high in Pre-normal.
- R4: With the hold complete and the synchronized `en_pin` high, Pre-normal moves to Normal (`mode_code` = 5'b00100). Normal has `tx_en` = 1, `reg_tight` = 1, `term_en` = 1 and `nres` = 1.
- R5: A falling edge on `en_pin` in Normal while `txd_pin` is high enters Silent (`mode_code` = 5'b01000). Silent has `reg_en` = 1, `reg_tight` = 0, `tx_en` = 0, `term_en` = 0 and `nres` = 1. A high `en_pin` in Silent returns the mode to Normal.
- R6: A falling edge on `en_pin` in Normal while `txd_pin` is low enters Sleep (`mode_code` = 5'b10000), with `reg_en` = 0 and `nres` = 0. In Sleep, `en_pin` edges or levels and `vcc_uv` have no effect on the mode.
- R7: If `vcc_uv` stays high in Normal or Silent for DEBOUNCE_TICKS consecutive ticks, the mode goes to Pre-normal with `nres` = 0, and the full reset hold of R2 follows. A shorter pulse leaves the mode and `nres` unchanged.
- R8: A `wake` pulse in Silent enters Pre-normal with `term_en` = 1 and `txd_pulldown` = 1. No new hold is started, so `nres` stays 1. `txd_pulldown` returns to 0 when Pre-normal is left.
- R9: A `wake` pulse in Sleep enters Pre-normal with `reg_en` = 1 and `txd_pulldown` = 1. The full reset hold of R2 applies before Normal can be entered.
- R10: From any mode, `supply_ok` low at a clock edge makes the mode Unpowered after that edge.
- R11: `mode_code` is one-hot: bit 0 Unpowered, bit 1 Pre-normal, bit 2 Normal, bit 3 Silent, bit 4 Sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable that paces every timed interval |
| supply_ok | input | 1 | Battery supply above its threshold |
| vcc_uv | input | 1 | Regulator output below its undervoltage threshold |
| en_pin | input | 1 | Host enable pin, asynchronous |
| txd_pin | input | 1 | Host transmit-data pin, asynchronous |
| wake | input | 1 | Validated bus wake-up pulse |
| reg_en | output | 1 | Regulator on |
| reg_tight | output | 1 | Regulator in tight-tolerance setting |
| tx_en | output | 1 | Transmit path enabled |
| term_en | output | 1 | Slave termination enabled |
| nres | output | 1 | Active-low reset to the host |
| txd_pulldown | output | 1 | Request to pull the transmit-data pin low |
| mode_code | output | 5 | One-hot mode code |

## Verification
The enable falling edge is applied once with transmit-data high and once with it low. This shows that the level sampled beside the edge, and not the edge alone, chooses between Silent and Sleep. Undervoltage is applied both as a pulse shorter than the debounce and as a sustained level, which separates a debounced exit from a raw one. A pulse during the reset hold shows that the hold restarts. Wake-ups are sent from Silent and from Sleep, and only the Sleep case must bring a new reset hold. Enable is held high through the hold and with ticks stopped, which shows that the hold counts ticks and blocks the move to Normal.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

   typedef enum logic [4:0] {
      M_OFF   = 5'b00001,
      M_PRE   = 5'b00010,
      M_RUN   = 5'b00100,
      M_QUIET = 5'b01000,
      M_DOZE  = 5'b10000
   } lin_mode_e;

endpackage

// File: rtl/lin_pin_sync.sv
module lin_pin_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_pin,
   input  logic txd_pin,
   output logic en_lvl,
   output logic txd_lvl,
   output logic en_fall
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("lin_pin_sync: SYNC_STAGES must be at least 2");
   end

   logic [LAST:0] en_q;
   logic [LAST:0] txd_q;
   logic          en_prev;

   // EN rests low (pull-down), TXD rests high (pull-up)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         txd_q   <= '1;
         en_prev <= 1'b0;
      end else begin
         en_q    <= {en_q[LAST-1:0], en_pin};
         txd_q   <= {txd_q[LAST-1:0], txd_pin};
         en_prev <= en_q[LAST];
      end
   end

   assign en_lvl  = en_q[LAST];
   assign txd_lvl = txd_q[LAST];
   assign en_fall = en_prev & ~en_q[LAST];

endmodule

// File: rtl/lin_tick_timer.sv
module lin_tick_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic restart,
   input  logic run,
   output logic done
);
   localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

   if (LIMIT < 0 || LIMIT > 16777215) begin : g_bad_limit
      $error("lin_tick_timer: LIMIT out of range");
   end

   if (LIMIT == 0) begin : g_none
      assign done = 1'b1;
   end else begin : g_cnt
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt <= '0;
         else if (restart)
            cnt <= '0;
         else if (run && tick && (cnt != CW'(LIMIT)))
            cnt <= cnt + 1'b1;
      end

      assign done = (cnt == CW'(LIMIT));

      // count never passes its limit (R3)
      assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= CW'(LIMIT));

      // without a tick the count cannot move (R3)
      assert_tick_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (!tick && !restart) |=> $stable(cnt));
   end

endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
   import lin_mode_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      supply_ok,
   input  logic      vcc_uv,
   input  logic      wake,
   input  logic      en_lvl,
   input  logic      en_fall,
   input  logic      txd_lvl,
   input  logic      hold_done,
   input  logic      uv_done,
   output lin_mode_e state,
   output logic      hold_restart,
   output logic      uv_run,
   output logic      wake_flag
);
   lin_mode_e state_nxt;
   logic      wake_nxt;
   logic      active;

   assign active = (state == M_RUN) || (state == M_QUIET);
   assign uv_run = vcc_uv && active;

   always_comb begin
      state_nxt    = state;
      wake_nxt     = 1'b0;
      hold_restart = 1'b0;
      if (!supply_ok) begin
         state_nxt = M_OFF;
      end else begin
         unique case (state)
            M_OFF: begin
               state_nxt    = M_PRE;
               hold_restart = 1'b1;
            end
            M_PRE: begin
               wake_nxt = wake_flag;
               if (vcc_uv)
                  hold_restart = 1'b1;
               else if (hold_done && en_lvl)
                  state_nxt = M_RUN;
            end
            M_RUN: begin
               if (uv_done) begin
                  state_nxt    = M_PRE;
                  hold_restart = 1'b1;
               end else if (en_fall) begin
                  state_nxt = txd_lvl ? M_QUIET : M_DOZE;
               end
            end
            M_QUIET: begin
               if (uv_done) begin
                  state_nxt    = M_PRE;
                  hold_restart = 1'b1;
               end else if (wake) begin
                  state_nxt = M_PRE;
                  wake_nxt  = 1'b1;
               end else if (en_lvl) begin
                  state_nxt = M_RUN;
               end
            end
            M_DOZE: begin
               if (wake) begin
                  state_nxt    = M_PRE;
                  wake_nxt     = 1'b1;
                  hold_restart = 1'b1;
               end
            end
            default: state_nxt = M_OFF;
         endcase
      end
      if (state_nxt != M_PRE)
         wake_nxt = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= M_OFF;
         wake_flag <= 1'b0;
      end else begin
         state     <= state_nxt;
         wake_flag <= wake_nxt;
      end
   end

   assert_supply_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> (state == M_OFF));

   assert_power_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == M_OFF && supply_ok) |=> (state == M_PRE));

   assert_hold_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == M_PRE && !hold_done) |=> (state == M_PRE || state == M_OFF));

   assert_sleep_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == M_DOZE && supply_ok && !wake) |=> (state == M_DOZE));

   assert_uv_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (uv_done && supply_ok && active) |=> (state == M_PRE));

   assert_quiet_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == M_QUIET && wake && supply_ok && !uv_done) |=> (state == M_PRE && wake_flag));

endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
   import lin_mode_pkg::*;
#(
   parameter int RESET_TICKS    = 10000,
   parameter int DEBOUNCE_TICKS = 4,
   parameter int SYNC_STAGES    = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       supply_ok,
   input  logic       vcc_uv,
   input  logic       en_pin,
   input  logic       txd_pin,
   input  logic       wake,
   output logic       reg_en,
   output logic       reg_tight,
   output logic       tx_en,
   output logic       term_en,
   output logic       nres,
   output logic       txd_pulldown,
   output logic [4:0] mode_code
);
   if (RESET_TICKS < 1) begin : g_bad_hold
      $error("lin_mode_ctrl: RESET_TICKS must be at least 1");
   end

   logic      en_lvl, txd_lvl, en_fall;
   logic      hold_done, hold_restart;
   logic      uv_done, uv_run;
   logic      wake_flag;
   lin_mode_e state;

   lin_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_pin  (en_pin),
      .txd_pin (txd_pin),
      .en_lvl  (en_lvl),
      .txd_lvl (txd_lvl),
      .en_fall (en_fall)
   );

   lin_tick_timer #(.LIMIT(RESET_TICKS)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .restart (hold_restart),
      .run     (state == M_PRE),
      .done    (hold_done)
   );

   lin_tick_timer #(.LIMIT(DEBOUNCE_TICKS)) u_uvdb (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .restart (!uv_run),
      .run     (uv_run),
      .done    (uv_done)
   );

   lin_mode_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .supply_ok    (supply_ok),
      .vcc_uv       (vcc_uv),
      .wake         (wake),
      .en_lvl       (en_lvl),
      .en_fall      (en_fall),
      .txd_lvl      (txd_lvl),
      .hold_done    (hold_done),
      .uv_done      (uv_done),
      .state        (state),
      .hold_restart (hold_restart),
      .uv_run       (uv_run),
      .wake_flag    (wake_flag)
   );

   always_comb begin
      reg_en       = (state != M_OFF) && (state != M_DOZE);
      reg_tight    = (state == M_PRE) || (state == M_RUN);
      tx_en        = (state == M_RUN);
      term_en      = (state == M_PRE) || (state == M_RUN);
      nres         = (state == M_RUN) || (state == M_QUIET) ||
                     ((state == M_PRE) && hold_done);
      txd_pulldown = (state == M_PRE) && wake_flag;
      mode_code    = state;
   end

   // the host reset may only release in Pre-normal once the hold has run out (R2)
   assert_nres_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(nres) && state == M_PRE) |-> hold_done);

endmodule

// File: tb/lin_mode_ctrl_test.sv
`timescale 1ns/1ps
module lin_mode_ctrl_test;
   localparam int HOLD = 20;
   localparam int DEB  = 3;
   localparam logic [4:0] C_OFF = 5'b00001, C_PRE = 5'b00010, C_RUN = 5'b00100,
                          C_QUIET = 5'b01000, C_DOZE = 5'b10000;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, supply_ok = 1'b0, vcc_uv = 1'b0;
   logic en_pin = 1'b0, txd_pin = 1'b1, wake = 1'b0;
   logic reg_en, reg_tight, tx_en, term_en, nres, txd_pulldown;
   logic [4:0] mode_code;
   int checks = 0, failures = 0;

   always #5 clk = ~clk;

   lin_mode_ctrl #(.RESET_TICKS(HOLD), .DEBOUNCE_TICKS(DEB), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok), .vcc_uv(vcc_uv),
      .en_pin(en_pin), .txd_pin(txd_pin), .wake(wake), .reg_en(reg_en),
      .reg_tight(reg_tight), .tx_en(tx_en), .term_en(term_en), .nres(nres),
      .txd_pulldown(txd_pulldown), .mode_code(mode_code)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic t_reset();
      step(3);
      chk("R1", "mode in reset", 32'(mode_code), 32'(C_OFF));
      chk("R1", "nres in reset", 32'(nres), 0);
      chk("R1", "reg_en in reset", 32'(reg_en), 0);
      rst_n = 1'b1;
      step(2);
      chk("R1", "mode without supply", 32'(mode_code), 32'(C_OFF));
   endtask

   task automatic t_powerup();
      supply_ok = 1'b1;
      step(1);
      chk("R1", "mode after supply rise, EN low", 32'(mode_code), 32'(C_PRE));
      chk("R2", "reg_en", 32'(reg_en), 1);
      chk("R2", "reg_tight", 32'(reg_tight), 1);
      chk("R2", "tx_en", 32'(tx_en), 0);
      chk("R2", "term_en", 32'(term_en), 1);
      chk("R2", "nres held", 32'(nres), 0);
      tick = 1'b0; en_pin = 1'b1;
      step(30);
      chk("R3", "no progress without tick", 32'(mode_code), 32'(C_PRE));
      chk("R3", "nres still low without tick", 32'(nres), 0);
      tick = 1'b1;
      step(10);
      chk("R2", "EN high refused during hold", 32'(mode_code), 32'(C_PRE));
      vcc_uv = 1'b1; step(2); vcc_uv = 1'b0;
      step(15);
      chk("R3", "hold restarted by undervoltage", 32'(mode_code), 32'(C_PRE));
      chk("R3", "nres low after restart", 32'(nres), 0);
      step(10);
      chk("R4", "mode after hold", 32'(mode_code), 32'(C_RUN));
      chk("R4", "nres released", 32'(nres), 1);
      chk("R4", "tx_en", 32'(tx_en), 1);
      chk("R4", "reg_tight", 32'(reg_tight), 1);
   endtask

   task automatic t_silent();
      txd_pin = 1'b1; en_pin = 1'b0;
      step(6);
      chk("R5", "mode after EN fall, TXD high", 32'(mode_code), 32'(C_QUIET));
      chk("R5", "reg_en", 32'(reg_en), 1);
      chk("R5", "reg_tight loose", 32'(reg_tight), 0);
      chk("R5", "tx_en", 32'(tx_en), 0);
      chk("R5", "term_en", 32'(term_en), 0);
      chk("R5", "nres", 32'(nres), 1);
      en_pin = 1'b1; step(6);
      chk("R5", "EN high returns to Normal", 32'(mode_code), 32'(C_RUN));
   endtask

   task automatic t_undervoltage();
      en_pin = 1'b0; txd_pin = 1'b1; step(6);
      vcc_uv = 1'b1; step(2); vcc_uv = 1'b0; step(2);
      chk("R7", "short glitch ignored", 32'(mode_code), 32'(C_QUIET));
      chk("R7", "nres after glitch", 32'(nres), 1);
      vcc_uv = 1'b1; step(6);
      chk("R7", "debounced undervoltage", 32'(mode_code), 32'(C_PRE));
      chk("R7", "nres low", 32'(nres), 0);
      vcc_uv = 1'b0; step(10);
      chk("R7", "nres held after recovery", 32'(nres), 0);
      step(25);
      chk("R7", "nres released after hold", 32'(nres), 1);
      chk("R7", "stays Pre-normal with EN low", 32'(mode_code), 32'(C_PRE));
      en_pin = 1'b1; step(6);
      chk("R4", "EN high to Normal", 32'(mode_code), 32'(C_RUN));
   endtask

   task automatic t_silent_wake();
      en_pin = 1'b0; txd_pin = 1'b1; step(6);
      wake = 1'b1; step(1); wake = 1'b0;
      chk("R8", "mode after wake from Silent", 32'(mode_code), 32'(C_PRE));
      chk("R8", "txd_pulldown", 32'(txd_pulldown), 1);
      chk("R8", "term_en", 32'(term_en), 1);
      chk("R8", "nres stays high", 32'(nres), 1);
      en_pin = 1'b1; step(6);
      chk("R8", "Normal after wake", 32'(mode_code), 32'(C_RUN));
      chk("R8", "txd_pulldown dropped", 32'(txd_pulldown), 0);
   endtask

   task automatic t_sleep();
      txd_pin = 1'b0; en_pin = 1'b0; step(6);
      chk("R6", "mode after EN fall, TXD low", 32'(mode_code), 32'(C_DOZE));
      chk("R6", "reg_en off", 32'(reg_en), 0);
      chk("R6", "nres low", 32'(nres), 0);
      txd_pin = 1'b1; en_pin = 1'b1; step(8);
      chk("R6", "EN high ignored", 32'(mode_code), 32'(C_DOZE));
      en_pin = 1'b0; step(6);
      chk("R6", "EN fall ignored", 32'(mode_code), 32'(C_DOZE));
      vcc_uv = 1'b1; step(6);
      chk("R6", "undervoltage ignored", 32'(mode_code), 32'(C_DOZE));
      vcc_uv = 1'b0;
      wake = 1'b1; step(1); wake = 1'b0;
      chk("R9", "mode after wake from Sleep", 32'(mode_code), 32'(C_PRE));
      chk("R9", "reg_en on", 32'(reg_en), 1);
      chk("R9", "txd_pulldown", 32'(txd_pulldown), 1);
      chk("R9", "nres held", 32'(nres), 0);
      en_pin = 1'b1; step(10);
      chk("R9", "hold blocks Normal", 32'(mode_code), 32'(C_PRE));
      step(20);
      chk("R9", "Normal after hold", 32'(mode_code), 32'(C_RUN));
      chk("R9", "txd_pulldown dropped", 32'(txd_pulldown), 0);
   endtask

   task automatic t_supply_loss();
      supply_ok = 1'b0; step(1);
      chk("R10", "mode after supply loss", 32'(mode_code), 32'(C_OFF));
      chk("R10", "nres", 32'(nres), 0);
      chk("R10", "reg_en", 32'(reg_en), 0);
      chk("R10", "tx_en", 32'(tx_en), 0);
      supply_ok = 1'b1; step(1);
      chk("R1", "re-entry to Pre-normal", 32'(mode_code), 32'(C_PRE));
      chk("R11", "one-hot code", 32'($countones(mode_code)), 1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_powerup();
      t_silent();
      t_undervoltage();
      t_silent_wake();
      t_sleep();
      t_supply_loss();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule